// File: doc/BRIEF.md
# Flash Busy-Status Responder

This block is the status side of a behavioural flash-memory model. Once a program or erase operation has been launched (a single start strobe standing for the last write of the command sequence), the model runs an internal timed operation. While it runs, reads aimed at the operation's target return a status byte whose top bit reports progress. All other reads return the stored word. When the operation ends, its effect is applied to the storage and every read returns stored data again.

Durations are counted in clock cycles that stand in for milliseconds, so a simulation stays short. A program to a protected sector, or an erase whose selected sectors are all protected, still shows a busy window of its own length. It then ends with the storage unchanged. An erase that selects a mix of protected and unprotected sectors clears only the unprotected ones.

The storage holds 2^ADDR_W words. The sector of an address is its top SECT_W bits, so with the defaults there are four sectors of sixteen words.

Top module: `flash_status_responder`

## Requirements
- R1: After reset `busy` is 0, `rd_valid` is 0 and every stored word is all ones, so a read returns 0xFF.
- R2: A read requested with `rd_en` high at a clock edge returns its byte on `rd_data` after that edge, with `rd_valid` high for that one cycle.
- R3: While a program runs, a read of exactly the program address returns a status byte. Bit 7 of that byte is the inverse of bit 7 of the program data, and bits 6..0 are zero. Reads of any other address return stored data.
- R4: A completed program to an unprotected sector stores the bitwise AND of the old word and the program data.
- R5: An unprotected program keeps `busy` high for PROG_CYC cycles, counted from the edge that accepts `op_start`. The next read after that returns stored data.
- R6: A program whose target sector has its `sect_prot` bit set keeps `busy` high for PROT_PROG_CYC cycles, returns the R3 status byte meanwhile, and leaves the word unchanged.
- R7: While an erase runs, a read of any address in a sector selected in `sect_sel` returns 0x00 (bit 7 is 0). Reads outside the selected sectors return stored data.
- R8: An erase with at least one selected, unprotected sector keeps `busy` high for ERASE_CYC cycles. It then sets every word of those sectors to all ones and leaves the selected protected sectors unchanged.
- R9: An erase in which no selected sector is unprotected keeps `busy` high for PROT_ERASE_CYC cycles and changes no word.
- R10: `op_start` while `busy` is high is ignored. The running operation keeps its kind, target, data, masks and duration.
- R11: `op_erase`, `op_addr`, `op_data`, `sect_sel` and `sect_prot` are sampled only on the edge that accepts `op_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Launch strobe for a program or erase |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| op_addr | input | ADDR_W | Program target address |
| op_data | input | DATA_W | Program data |
| sect_sel | input | 2^SECT_W | Sectors chosen for erase, one bit per sector |
| sect_prot | input | 2^SECT_W | Protected sectors, one bit per sector |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Returned status byte or stored word |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous request |
| busy | output | 1 | An operation is running |

## Verification
`busy` rises one edge after `op_start` is sampled. It falls exactly N edges after that sample, where N is the duration chosen for the operation. The storage changes on the same edge on which `busy` falls. A read answer appears one edge after the request. A read sampled while `busy` is still high therefore reports status, and the first read after the fall reports the updated word. The bench drives stimulus and samples outputs one nanosecond after each rising edge. It counts the sampled cycles with `busy` high and compares that count with the expected duration. Every read is checked at the sample that directly follows its request edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_t;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction
endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (load)   cnt <= load_val;
      else if (busy)   cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CNT_W'(1));

   // The requested duration is taken on load (R5)
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val)));

   // The final count ends the busy window (R5)
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done && !load |=> !busy);
endmodule

// File: rtl/fsr_array.sv
module fsr_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int SECT_W = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prog_we,
   input  logic [ADDR_W-1:0]     prog_addr,
   input  logic [DATA_W-1:0]     prog_data,
   input  logic                  ers_we,
   input  logic [(1<<SECT_W)-1:0] ers_mask,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [DATA_W-1:0]     rd_word
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int WPS   = 1 << (ADDR_W - SECT_W);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ers_we && ers_mask[i / WPS])
               mem[i] <= '1;
            else if (prog_we && (prog_addr == ADDR_W'(i)))
               mem[i] <= mem[i] & prog_data;
         end
      end
   end

   assign rd_word = mem[rd_addr];

   // Programming only clears bits (R4)
   assert_prog_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we && !ers_we |=> (mem[$past(prog_addr)] == ($past(mem[prog_addr]) & $past(prog_data))));
endmodule

// File: rtl/fsr_read_port.sv
module fsr_read_port #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8,
   parameter int SECT_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      rd_addr,
   input  logic                   busy,
   input  fsr_pkg::op_kind_t      kind,
   input  logic [ADDR_W-1:0]      tgt_addr,
   input  logic                   tgt_bit7,
   input  logic [(1<<SECT_W)-1:0] tgt_sel,
   input  logic [DATA_W-1:0]      arr_word,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   rd_valid
);
   logic [SECT_W-1:0] rd_sect;
   logic              hit;
   logic [DATA_W-1:0] status_byte;

   assign rd_sect = rd_addr[ADDR_W-1 -: SECT_W];

   always_comb begin
      if (kind == fsr_pkg::OP_ERASE) hit = busy && tgt_sel[rd_sect];
      else                           hit = busy && (rd_addr == tgt_addr);
   end

   assign status_byte = {(kind == fsr_pkg::OP_ERASE) ? 1'b0 : ~tgt_bit7,
                         {(DATA_W-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= hit ? status_byte : arr_word;
      end
   end

   // Answer arrives one edge after the request (R2)
   assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);

   // An idle block always answers with stored data (R3)
   assert_idle_array_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !busy |=> (rd_data == $past(arr_word)));
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder #(
   parameter int ADDR_W         = 6,
   parameter int DATA_W         = 8,
   parameter int SECT_W         = 2,
   parameter int PROG_CYC       = 6,
   parameter int ERASE_CYC      = 10,
   parameter int PROT_PROG_CYC  = 16,
   parameter int PROT_ERASE_CYC = 40
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_start,
   input  logic                   op_erase,
   input  logic [ADDR_W-1:0]      op_addr,
   input  logic [DATA_W-1:0]      op_data,
   input  logic [(1<<SECT_W)-1:0] sect_sel,
   input  logic [(1<<SECT_W)-1:0] sect_prot,
   input  logic                   rd_en,
   input  logic [ADDR_W-1:0]      rd_addr,
   output logic [DATA_W-1:0]      rd_data,
   output logic                   rd_valid,
   output logic                   busy
);
   import fsr_pkg::*;

   localparam int NSECT = 1 << SECT_W;
   localparam int MAXC  = max_of4(PROG_CYC, ERASE_CYC, PROT_PROG_CYC, PROT_ERASE_CYC);
   localparam int CNT_W = $clog2(MAXC + 1);

   generate
      if (PROG_CYC < 2 || ERASE_CYC < 2 || PROT_PROG_CYC < 2 || PROT_ERASE_CYC < 2)
         $error("operation durations must be at least two cycles");
      if (SECT_W < 1 || SECT_W >= ADDR_W)
         $error("SECT_W must lie between 1 and ADDR_W-1");
      if (DATA_W < 2)
         $error("DATA_W must be at least 2");
   endgenerate

   logic             accept;
   logic [CNT_W-1:0] load_val;
   logic             done;
   logic             tgt_prot;
   logic [NSECT-1:0] live_mask;

   op_kind_t          cur_kind;
   logic [ADDR_W-1:0] cur_addr;
   logic [DATA_W-1:0] cur_data;
   logic [NSECT-1:0]  cur_sel;
   logic [NSECT-1:0]  cur_live;
   logic              cur_prog_ok;
   logic [DATA_W-1:0] arr_word;

   assign accept    = op_start && !busy;
   assign tgt_prot  = sect_prot[op_addr[ADDR_W-1 -: SECT_W]];
   assign live_mask = sect_sel & ~sect_prot;

   always_comb begin
      if (op_erase) load_val = (live_mask == '0) ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(ERASE_CYC);
      else          load_val = tgt_prot ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_kind    <= OP_PROG;
         cur_addr    <= '0;
         cur_data    <= '0;
         cur_sel     <= '0;
         cur_live    <= '0;
         cur_prog_ok <= 1'b0;
      end else if (accept) begin
         cur_kind    <= op_erase ? OP_ERASE : OP_PROG;
         cur_addr    <= op_addr;
         cur_data    <= op_data;
         cur_sel     <= sect_sel;
         cur_live    <= live_mask;
         cur_prog_ok <= !tgt_prot;
      end
   end

   fsr_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (load_val),
      .busy     (busy),
      .done     (done)
   );

   fsr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .prog_we   (done && (cur_kind == OP_PROG) && cur_prog_ok),
      .prog_addr (cur_addr),
      .prog_data (cur_data),
      .ers_we    (done && (cur_kind == OP_ERASE)),
      .ers_mask  (cur_live),
      .rd_addr   (rd_addr),
      .rd_word   (arr_word)
   );

   fsr_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .busy     (busy),
      .kind     (cur_kind),
      .tgt_addr (cur_addr),
      .tgt_bit7 (cur_data[DATA_W-1]),
      .tgt_sel  (cur_sel),
      .arr_word (arr_word),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   // A start during a running operation leaves it untouched (R10, R11)
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy && op_start |=> ($stable(cur_addr) && $stable(cur_data) &&
                            $stable(cur_kind) && $stable(cur_sel) && $stable(cur_live)));
endmodule

// File: tb/flash_status_responder_test.sv
`timescale 1ns/1ps
module flash_status_responder_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_start = 1'b0;
   logic       op_erase = 1'b0;
   logic [5:0] op_addr = '0;
   logic [7:0] op_data = '0;
   logic [3:0] sect_sel = '0;
   logic [3:0] sect_prot = '0;
   logic       rd_en = 1'b0;
   logic [5:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       rd_valid;
   logic       busy;

   int checks = 0;
   int errors = 0;
   int busy_cycles = 0;
   logic [7:0] got;

   always #2 clk = ~clk;

   flash_status_responder uut (
      .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(op_erase),
      .op_addr(op_addr), .op_data(op_data), .sect_sel(sect_sel), .sect_prot(sect_prot),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      if (busy) busy_cycles++;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d);
      rd_en = 1'b1;
      rd_addr = a;
      tick();
      d = rd_data;
      if (!rd_valid) check("R2 rd_valid", 0, 1);
      rd_en = 1'b0;
   endtask

   task automatic start(input logic er, input logic [5:0] a, input logic [7:0] d,
                        input logic [3:0] sel, input logic [3:0] prot);
      op_erase = er; op_addr = a; op_data = d; sect_sel = sel; sect_prot = prot;
      op_start = 1'b1;
      @(posedge clk);
      #1;
      op_start = 1'b0;
      busy_cycles = busy ? 1 : 0;
      // R11: inputs scrambled after the accepting edge
      op_erase = ~er; op_addr = ~a; op_data = ~d; sect_sel = ~sel; sect_prot = ~prot;
   endtask

   task automatic finish_op();
      while (busy) tick();
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 rd_valid", rd_valid, 0);
      rd(6'd0, got);  check("R1 word0", got, 8'hFF);
      rd(6'd63, got); check("R2 word63", got, 8'hFF);
   endtask

   task automatic t_program();
      start(1'b0, 6'd5, 8'h5A, 4'b0000, 4'b0000);
      rd(6'd5, got);  check("R3 status", got, 8'h80);
      rd(6'd20, got); check("R3 other addr", got, 8'hFF);
      finish_op();
      check("R5 duration", busy_cycles, 6);
      rd(6'd5, got);  check("R5 after done", got, 8'h5A);
      start(1'b0, 6'd5, 8'hF0, 4'b0000, 4'b0000);
      rd(6'd5, got);  check("R3 status bit7 one", got, 8'h00);
      finish_op();
      rd(6'd5, got);  check("R4 AND result", got, 8'h50);
   endtask

   task automatic t_prot_program();
      start(1'b0, 6'd17, 8'h00, 4'b0000, 4'b0010);
      rd(6'd17, got); check("R6 status", got, 8'h80);
      finish_op();
      check("R6 duration", busy_cycles, 16);
      rd(6'd17, got); check("R6 unchanged", got, 8'hFF);
   endtask

   task automatic t_erase_mixed();
      start(1'b0, 6'd18, 8'h12, 4'b0000, 4'b0000);
      finish_op();
      rd(6'd18, got); check("R4 seed", got, 8'h12);
      start(1'b1, 6'd0, 8'h00, 4'b0011, 4'b0010);
      rd(6'd3, got);  check("R7 status sel", got, 8'h00);
      rd(6'd18, got); check("R7 status sel prot", got, 8'h00);
      rd(6'd40, got); check("R7 unselected", got, 8'hFF);
      finish_op();
      check("R8 duration", busy_cycles, 10);
      rd(6'd5, got);  check("R8 erased", got, 8'hFF);
      rd(6'd18, got); check("R8 protected kept", got, 8'h12);
   endtask

   task automatic t_erase_all_prot();
      start(1'b1, 6'd0, 8'h00, 4'b0010, 4'b0010);
      rd(6'd18, got); check("R9 status", got, 8'h00);
      finish_op();
      check("R9 duration", busy_cycles, 40);
      rd(6'd18, got); check("R9 unchanged", got, 8'h12);
   endtask

   task automatic t_start_while_busy();
      start(1'b0, 6'd40, 8'h00, 4'b0000, 4'b0000);
      op_erase = 1'b1; sect_sel = 4'b0100; sect_prot = 4'b0000; op_addr = 6'd40;
      op_start = 1'b1;
      tick();
      op_start = 1'b0;
      finish_op();
      check("R10 duration kept", busy_cycles, 6);
      rd(6'd40, got); check("R10 program kept", got, 8'h00);
      rd(6'd41, got); check("R10 no erase", got, 8'hFF);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_program();
      t_prot_program();
      t_erase_mixed();
      t_erase_all_prot();
      t_start_while_busy();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule